// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It brings the memory device from power-on to a usable state. After a synchronous reset it holds the clock-enable pin low and drives only no-operation commands. It does this for a stable-clock interval. That interval is a parameter in microseconds, converted to clock cycles from a clock-period parameter. It then raises clock enable and issues a fixed chain of one-cycle commands, with NOP filling every cycle between them. The chain precharges all banks, programs the extended mode register to enable the delay-locked loop, and loads the mode register with the DLL-reset bit set. It then precharges all banks again, issues a configurable number of auto-refreshes, and loads the operating mode with the DLL-reset bit cleared.

Each command is followed by the wait its class needs: tRP after a precharge-all, tRFC after a refresh, and a short fixed gap after a mode-register load. A separate window counts the DLL lock time from the DLL-reset load. The ready flag waits for both that window and the final gap. Once ready is high, the sequencer goes quiet until the next reset. All pins are plain control and status; there is no streaming data path, so no valid/ready handshake or back-pressure applies.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is sampled high, and in the cycle after the reset edge, cke is 0, cmd is NOP, addr is 0 and ready is 0. A reset at any later point restarts the whole sequence.
- R2: After reset is released, cke stays 0 and cmd stays NOP through edge STABLE_CYC−1, where STABLE_CYC = STABLE_US·1 000 000 / CLK_PERIOD_PS. After edge STABLE_CYC, cke is 1 with cmd still NOP.
- R3: The cmd encoding is NOP=0, PALL=1, EMRS=2, MRS=3, REF=4. Every non-NOP command lasts exactly one cycle, and every cycle between commands carries NOP with addr 0.
- R4: Non-NOP commands appear in this order: PALL, EMRS, MRS, PALL, then N_REF REF commands, then MRS.
- R5: The first PALL follows the cke rise by one cycle. Every PALL carries addr bit 10 set and all other address bits clear.
- R6: The EMRS carries EMRS_VAL. The first MRS carries MRS_VAL with bit 8 forced to 1. The last MRS carries MRS_VAL with bit 8 forced to 0.
- R7: The next command comes T_RP cycles after each PALL, and MRS_GAP cycles after each EMRS or MRS.
- R8: Consecutive REF commands are T_RFC cycles apart, and the last MRS comes T_RFC cycles after the last REF.
- R9: ready rises exactly at the later of (last MRS + MRS_GAP) and (first MRS + DLL_LOCK), never earlier.
- R10: Once ready is 1 it stays 1, cke stays 1 and cmd stays NOP until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory device |
| cmd | output | 3 | Command code (NOP=0, PALL=1, EMRS=2, MRS=3, REF=4) |
| addr | output | ADDR_W | Address bus carrying mode-register and precharge values |
| ready | output | 1 | Initialization complete |

## Verification
The assertions guard, on every cycle, the invariants that involve no count:
- NOP only while clock enable is low.
- One-cycle commands.
- Bit 10 on precharge-all.
- A sticky ready and clock enable, with ready never rising before the DLL window reports lock.

Only the bench's cycle-exact reference model can show the rest:
- The command order and the exact tRP, tRFC and mode-gap spacing.
- The mode-register address values.
- The ready time taken as the later of two deadlines.

Two parameter sets are used so that each deadline is the later one once. Mid-sequence and post-ready resets show that the whole chain restarts.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PALL = 3'd1,
    CMD_EMRS = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_REF  = 3'd4
  } dram_cmd_e;

  typedef enum logic [3:0] {
    STP_CKE,
    STP_PALL_A,
    STP_EMRS,
    STP_MRS_DLL,
    STP_PALL_B,
    STP_REF,
    STP_MRS_RUN,
    STP_SETTLE,
    STP_READY
  } init_step_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RESET_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_lock_window.sv
module ddr_init_lock_window #(
  parameter int unsigned LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic locked
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);

  logic          running_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start) begin
      running_q <= 1'b1;
      cnt_q     <= LW'(LOCK_CYC - 1);
    end else if (running_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign locked = running_q && (cnt_q == '0);

  AST_LOCK_NOT_AT_START: assert property (@(posedge clk) disable iff (rst)
    start |=> !locked); // R9
endmodule

// File: rtl/ddr_init_cmd_map.sv
module ddr_init_cmd_map
  import ddr_init_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 13,
  parameter int unsigned          CNT_W    = 8,
  parameter int unsigned          T_RP     = 3,
  parameter int unsigned          T_RFC    = 10,
  parameter int unsigned          MRS_GAP  = 2,
  parameter logic [ADDR_W-1:0]    EMRS_VAL = '0,
  parameter logic [ADDR_W-1:0]    MRS_VAL  = '0
) (
  input  init_step_e        step,
  output dram_cmd_e         cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  wait_m1
);
  localparam int unsigned DLL_BIT = 8;
  localparam int unsigned AP_BIT  = 10;

  logic [ADDR_W-1:0] pall_addr;
  logic [ADDR_W-1:0] mrs_dll_addr;
  logic [ADDR_W-1:0] mrs_run_addr;

  generate
    if (ADDR_W <= AP_BIT) begin : g_width_bad
      $error("ddr_init_cmd_map: ADDR_W must exceed 10");
    end else begin : g_width_ok
      always_comb begin
        pall_addr             = '0;
        pall_addr[AP_BIT]     = 1'b1;
        mrs_dll_addr          = MRS_VAL;
        mrs_dll_addr[DLL_BIT] = 1'b1;
        mrs_run_addr          = MRS_VAL;
        mrs_run_addr[DLL_BIT] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    cmd     = CMD_NOP;
    addr    = '0;
    wait_m1 = '0;
    unique case (step)
      STP_CKE: begin
        wait_m1 = '0;
      end
      STP_PALL_A, STP_PALL_B: begin
        cmd     = CMD_PALL;
        addr    = pall_addr;
        wait_m1 = CNT_W'(T_RP - 1);
      end
      STP_EMRS: begin
        cmd     = CMD_EMRS;
        addr    = EMRS_VAL;
        wait_m1 = CNT_W'(MRS_GAP - 1);
      end
      STP_MRS_DLL: begin
        cmd     = CMD_MRS;
        addr    = mrs_dll_addr;
        wait_m1 = CNT_W'(MRS_GAP - 1);
      end
      STP_REF: begin
        cmd     = CMD_REF;
        wait_m1 = CNT_W'(T_RFC - 1);
      end
      STP_MRS_RUN: begin
        cmd     = CMD_MRS;
        addr    = mrs_run_addr;
        wait_m1 = CNT_W'(MRS_GAP - 1);
      end
      default: begin
        cmd     = CMD_NOP;
      end
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 13,
  parameter int unsigned       CLK_PERIOD_PS = 10000,
  parameter int unsigned       STABLE_US     = 200,
  parameter int unsigned       T_RP          = 3,
  parameter int unsigned       T_RFC         = 10,
  parameter int unsigned       MRS_GAP       = 2,
  parameter int unsigned       N_REF         = 2,
  parameter int unsigned       DLL_LOCK      = 200,
  parameter logic [ADDR_W-1:0] EMRS_VAL      = '0,
  parameter logic [ADDR_W-1:0] MRS_VAL       = ADDR_W'('h062)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam int unsigned STABLE_CYC = (STABLE_US * 1000000) / CLK_PERIOD_PS;
  localparam int unsigned MAX_WAIT   = umax(STABLE_CYC, umax(T_RP, umax(T_RFC, MRS_GAP)));
  localparam int unsigned CNT_W      = $clog2(MAX_WAIT + 1);
  localparam int unsigned RC_W       = $clog2(N_REF) + 1;

  generate
    if (N_REF < 2 || T_RP < 2 || T_RFC < 2 || MRS_GAP < 2 || DLL_LOCK < 2 || STABLE_CYC < 1)
    begin : g_param_bad
      $error("ddr_init_seq: parameter below its minimum");
    end
  endgenerate

  init_step_e        step_q, step_nx;
  logic [RC_W-1:0]   ref_cnt_q;
  logic              cke_q, ready_q;
  dram_cmd_e         cmd_q;
  logic [ADDR_W-1:0] addr_q;

  dram_cmd_e         map_cmd;
  logic [ADDR_W-1:0] map_addr;
  logic [CNT_W-1:0]  map_wait_m1;
  logic              tmr_expired;
  logic              dll_locked;
  logic              fire;
  logic              lock_start;

  ddr_init_cmd_map #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .T_RP(T_RP), .T_RFC(T_RFC),
    .MRS_GAP(MRS_GAP), .EMRS_VAL(EMRS_VAL), .MRS_VAL(MRS_VAL)
  ) u_map (
    .step(step_q), .cmd(map_cmd), .addr(map_addr), .wait_m1(map_wait_m1)
  );

  ddr_init_gap_timer #(.CNT_W(CNT_W), .RESET_VAL(STABLE_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(fire), .load_val(map_wait_m1), .expired(tmr_expired)
  );

  ddr_init_lock_window #(.LOCK_CYC(DLL_LOCK)) u_lock (
    .clk(clk), .rst(rst), .start(lock_start), .locked(dll_locked)
  );

  assign fire       = tmr_expired && (step_q != STP_SETTLE) && (step_q != STP_READY);
  assign lock_start = fire && (step_q == STP_MRS_DLL);

  always_comb begin
    step_nx = step_q;
    unique case (step_q)
      STP_CKE:     step_nx = STP_PALL_A;
      STP_PALL_A:  step_nx = STP_EMRS;
      STP_EMRS:    step_nx = STP_MRS_DLL;
      STP_MRS_DLL: step_nx = STP_PALL_B;
      STP_PALL_B:  step_nx = STP_REF;
      STP_REF:     step_nx = (ref_cnt_q == RC_W'(N_REF - 1)) ? STP_MRS_RUN : STP_REF;
      STP_MRS_RUN: step_nx = STP_SETTLE;
      default:     step_nx = step_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= STP_CKE;
      ref_cnt_q <= '0;
      cke_q     <= 1'b0;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      ready_q   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      if (fire) begin
        cmd_q  <= map_cmd;
        addr_q <= map_addr;
        step_q <= step_nx;
        if (step_q == STP_CKE) cke_q <= 1'b1;
        if (step_q == STP_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
      end
      if (step_q == STP_SETTLE && tmr_expired && dll_locked) begin
        ready_q <= 1'b1;
        step_q  <= STP_READY;
      end
    end
  end

  assign cke   = cke_q;
  assign cmd   = cmd_q;
  assign addr  = addr_q;
  assign ready = ready_q;

  AST_CKE_LOW_ONLY_NOP: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd == CMD_NOP)); // R2
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP)); // R3
  AST_PALL_BIT10: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PALL) |-> addr[10]); // R5
  AST_READY_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> dll_locked); // R9
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R10
  AST_CKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke); // R10
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cmd == CMD_NOP && cke)); // R10
endmodule

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  localparam int CLK_NS = 10;
  localparam int AW     = 13;
  localparam int S_US   = 2;
  localparam int PER_PS = CLK_NS * 1000;
  localparam int S_CYC  = S_US * 1000000 / PER_PS;
  localparam int TRP    = 3;
  localparam int TRFC   = 12;
  localparam int GAP    = 2;
  localparam int LOCK   = 200;
  localparam int NREF0  = 3;
  localparam int NREF1  = 20;
  localparam logic [AW-1:0] EV0 = 13'h002;
  localparam logic [AW-1:0] MV0 = 13'h063;
  localparam logic [AW-1:0] MV1 = 13'h1A2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS/2) clk = ~clk;

  logic          cke0, cke1, rdy0, rdy1;
  logic [2:0]    cmd0, cmd1;
  logic [AW-1:0] adr0, adr1;

  ddr_init_seq #(.ADDR_W(AW), .CLK_PERIOD_PS(PER_PS), .STABLE_US(S_US), .T_RP(TRP),
    .T_RFC(TRFC), .MRS_GAP(GAP), .N_REF(NREF0), .DLL_LOCK(LOCK),
    .EMRS_VAL(EV0), .MRS_VAL(MV0)) u0 (
    .clk(clk), .rst(rst), .cke(cke0), .cmd(cmd0), .addr(adr0), .ready(rdy0));

  ddr_init_seq #(.ADDR_W(AW), .CLK_PERIOD_PS(PER_PS), .STABLE_US(S_US), .T_RP(TRP),
    .T_RFC(TRFC), .MRS_GAP(GAP), .N_REF(NREF1), .DLL_LOCK(LOCK),
    .EMRS_VAL(13'h000), .MRS_VAL(MV1)) u1 (
    .clk(clk), .rst(rst), .cke(cke1), .cmd(cmd1), .addr(adr1), .ready(rdy1));

  int n_chk  = 0;
  int n_fail = 0;
  int n_edge = 0;
  int seen[$];

  always @(posedge clk) begin
    if (rst) n_edge <= 0;
    else     n_edge <= n_edge + 1;
  end

  // Behavioural expectation for edge count n since reset release
  function automatic void model(input int n, input int nref, input logic [AW-1:0] ev,
                                input logic [AW-1:0] mv, output logic e_cke,
                                output logic [2:0] e_cmd, output logic [AW-1:0] e_adr,
                                output logic e_rdy, output string tag);
    int p1, e, m1, p2, r0, f, d;
    p1 = S_CYC + 1; e = p1 + TRP; m1 = e + GAP; p2 = m1 + GAP;
    r0 = p2 + TRP; f = r0 + nref * TRFC;
    d  = (f + GAP > m1 + LOCK) ? f + GAP : m1 + LOCK;
    e_cke = (n >= S_CYC); e_cmd = 3'd0; e_adr = '0; e_rdy = (n >= d);
    tag = "R3";
    if (n == 0) tag = "R1";
    else if (n <= S_CYC) tag = "R2";
    else if (n == p1 || n == p2) begin
      e_cmd = 3'd1; e_adr = 13'h400; tag = (n == p1) ? "R5" : "R7";
    end else if (n == e) begin
      e_cmd = 3'd2; e_adr = ev; tag = "R6";
    end else if (n == m1) begin
      e_cmd = 3'd3; e_adr = mv | 13'h100; tag = "R6";
    end else if (n == f) begin
      e_cmd = 3'd3; e_adr = mv & ~13'h100; tag = "R6";
    end else if (n >= r0 && n < f && ((n - r0) % TRFC) == 0) begin
      e_cmd = 3'd4; tag = "R8";
    end else if (n == d || n == d - 1) tag = "R9";
    else if (n > d) tag = "R10";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (edge %0d)", tag, what, act, exp, n_edge);
    end
  endtask

  task automatic compare(input string who, input int nref, input logic [AW-1:0] ev,
                         input logic [AW-1:0] mv, input logic a_cke, input logic [2:0] a_cmd,
                         input logic [AW-1:0] a_adr, input logic a_rdy);
    logic e_cke, e_rdy; logic [2:0] e_cmd; logic [AW-1:0] e_adr; string tag;
    model(n_edge, nref, ev, mv, e_cke, e_cmd, e_adr, e_rdy, tag);
    chk(tag, {who, " cke"},   int'(a_cke), int'(e_cke));
    chk(tag, {who, " cmd"},   int'(a_cmd), int'(e_cmd));
    chk(tag, {who, " addr"},  int'(a_adr), int'(e_adr));
    chk(tag, {who, " ready"}, int'(a_rdy), int'(e_rdy));
  endtask

  bit running = 1'b0;
  always @(negedge clk) begin
    if (running) begin
      compare("u0", NREF0, EV0, MV0, cke0, cmd0, adr0, rdy0);
      compare("u1", NREF1, 13'h000, MV1, cke1, cmd1, adr1, rdy1);
      if (rst) seen.delete();
      else if (cmd0 != 3'd0) seen.push_back(int'(cmd0));
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int exp_order[$];
    exp_order = {1, 2, 3, 1, 4, 4, 4, 3};
    repeat (3) @(posedge clk);
    @(negedge clk); running = 1'b1; rst = 1'b0;
    repeat (480) @(negedge clk);
    // R4: command order of the first full run
    chk("R4", "order length", seen.size(), exp_order.size());
    foreach (exp_order[i]) begin
      if (i < seen.size()) chk("R4", "order item", seen[i], exp_order[i]);
    end
    // R1: reset in the middle of the sequence
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (250) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (480) @(negedge clk);
    // R1: reset after ready, then a full rerun
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (480) @(negedge clk);
    summary();
  end
endmodule